// File: doc/BRIEF.md
# Channelled Inter-Processor Mailbox

This block passes 32-bit messages between a host processor and a co-processor. Each word carries a 4-bit channel number in its low bits and a 28-bit payload above it. The host places words for the co-processor by writing a single register. It collects replies by reading another register, and each such read removes the oldest reply. Before every access the host polls a status register. That register reports whether the outbound queue can take another word and whether any reply is waiting.

Each direction has its own small first-in first-out queue. The co-processor side sees the head of the outbound queue as a valid word, already split into channel and payload, together with a pop strobe. It pushes replies into the return queue and sees a full indication when that queue has no room. Host writes that meet a full queue are dropped and leave a sticky overflow mark. Host reads of an empty reply queue return zero. An optional interrupt tells the host that a reply is pending. The block does not interpret what the messages mean.

Top module: `chan_mailbox`

## Requirements
- R1: A message word holds its channel number in bits 3:0 and its payload in bits 31:4. The co-processor side presents the head word of the outbound queue split along that boundary.
- R2: A host write to offset 0x20 enqueues the word on the outbound queue when the queue is not full. The co-processor receives the words in write order, one per pop.
- R3: A host write to offset 0x20 while the outbound queue is full is discarded and sets the sticky overflow flag, status bit 29. A host write to offset 0x18 with bit 29 set clears the flag.
- R4: Status register at offset 0x18. Bit 31 is 1 when the outbound queue is full, bit 30 is 1 when the reply queue is empty, bit 29 is the overflow flag, and all other bits read as zero.
- R5: A host read of offset 0x00 returns the oldest reply on hostRdata in the cycle after the read strobe, and removes that reply from the queue.
- R6: A host read of offset 0x00 while the reply queue is empty returns zero and leaves the queue unchanged.
- R7: The control register at offset 0x1C holds the interrupt enable in bit 0 and reads back with all other bits zero. The irq output is high exactly while bit 0 is set and the reply queue is non-empty.
- R8: A co-processor push while the reply queue is full is discarded, and cpInFull is high while the queue holds DEPTH words.
- R9: After reset both queues are empty, the overflow flag and interrupt enable are clear, and irq and cpOutValid are low.
- R10: Each queue accepts exactly DEPTH words before it reports full. A read of any unmapped offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Host byte offset |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data, valid the cycle after hostRd |
| irq | output | 1 | Reply-pending interrupt |
| cpOutValid | output | 1 | Outbound queue has a word |
| cpOutChan | output | 4 | Channel of the outbound head word |
| cpOutPayload | output | 28 | Payload of the outbound head word |
| cpOutPop | input | 1 | Co-processor removes the outbound head word |
| cpInPush | input | 1 | Co-processor pushes a reply word |
| cpInData | input | 32 | Reply word |
| cpInFull | output | 1 | Reply queue is full |

## Verification
The bench builds the mailbox with DEPTH set to 4 instead of 8. A short queue lets it walk every fill level of both queues, from empty through full and one past full, on each of several rounds with distinct word patterns. At each level the full and empty status bits, the overflow flag, and the interrupt are compared with values computed from the fill count. Channel and payload values are derived arithmetically from the round and slot numbers. This exposes reordering, lost words, or a wrongly split word.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned CHAN_W   = 4;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned OFS_READ = 'h00;
  localparam int unsigned OFS_STAT = 'h18;
  localparam int unsigned OFS_CTRL = 'h1C;
  localparam int unsigned OFS_WRIT = 'h20;
  localparam int unsigned BIT_FULL = 31;
  localparam int unsigned BIT_EMPT = 30;
  localparam int unsigned BIT_OVF  = 29;

  typedef struct packed {
    logic pushOut;
    logic popReply;
    logic setOvf;
    logic clrOvf;
    logic wrCtrl;
    logic rdAny;
    logic selReply;
    logic selStatus;
    logic selCtrl;
  } mbox_strobe_t;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign full   = (count == CAP);
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign dout   = store[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) store[wrPtr] <= din;
  end
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              clrReq,
  input  logic              outFull,
  input  logic              replyEmpty,
  output mbox_strobe_t      strobe
);
  logic hitRead, hitStat, hitCtrl, hitWrit;

  assign hitRead = (hostAddr == ADDR_W'(OFS_READ));
  assign hitStat = (hostAddr == ADDR_W'(OFS_STAT));
  assign hitCtrl = (hostAddr == ADDR_W'(OFS_CTRL));
  assign hitWrit = (hostAddr == ADDR_W'(OFS_WRIT));

  always_comb begin
    strobe           = '0;
    strobe.pushOut   = hostWr && hitWrit && !outFull;
    strobe.setOvf    = hostWr && hitWrit && outFull;
    strobe.clrOvf    = hostWr && hitStat && clrReq;
    strobe.wrCtrl    = hostWr && hitCtrl;
    strobe.rdAny     = hostRd;
    strobe.selReply  = hostRd && hitRead;
    strobe.popReply  = hostRd && hitRead && !replyEmpty;
    strobe.selStatus = hostRd && hitStat;
    strobe.selCtrl   = hostRd && hitCtrl;
  end
endmodule

// File: rtl/mbox_datapath.sv
module mbox_datapath
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  mbox_strobe_t             strobe,
  input  logic [WORD_W-1:0]        hostWdata,
  output logic [WORD_W-1:0]        hostRdata,
  output logic                     irq,
  output logic                     outFull,
  output logic                     replyEmpty,
  output logic                     ovfFlag,
  output logic [CNT_W-1:0]         outCount,
  output logic [CNT_W-1:0]         replyCount,
  output logic                     cpOutValid,
  output logic [WORD_W-1:0]        cpOutWord,
  input  logic                     cpOutPop,
  input  logic                     cpInPush,
  input  logic [WORD_W-1:0]        cpInData,
  output logic                     cpInFull
);
  logic outEmpty;
  logic [WORD_W-1:0] replyHead;
  logic irqEnable;
  logic [WORD_W-1:0] statusWord;

  mbox_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) outQ (
    .clk(clk), .rstN(rstN),
    .push(strobe.pushOut), .din(hostWdata),
    .pop(cpOutPop), .dout(cpOutWord),
    .full(outFull), .empty(outEmpty), .count(outCount)
  );

  mbox_fifo #(.WIDTH(WORD_W), .DEPTH(DEPTH)) replyQ (
    .clk(clk), .rstN(rstN),
    .push(cpInPush), .din(cpInData),
    .pop(strobe.popReply), .dout(replyHead),
    .full(cpInFull), .empty(replyEmpty), .count(replyCount)
  );

  assign cpOutValid = !outEmpty;
  assign irq        = irqEnable && !replyEmpty;

  always_comb begin
    statusWord           = '0;
    statusWord[BIT_FULL] = outFull;
    statusWord[BIT_EMPT] = replyEmpty;
    statusWord[BIT_OVF]  = ovfFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag   <= 1'b0;
      irqEnable <= 1'b0;
      hostRdata <= '0;
    end else begin
      if (strobe.setOvf)      ovfFlag <= 1'b1;
      else if (strobe.clrOvf) ovfFlag <= 1'b0;
      if (strobe.wrCtrl) irqEnable <= hostWdata[0];
      if (strobe.rdAny) begin
        if (strobe.selReply)       hostRdata <= replyEmpty ? '0 : replyHead;
        else if (strobe.selStatus) hostRdata <= statusWord;
        else if (strobe.selCtrl)   hostRdata <= {{(WORD_W-1){1'b0}}, irqEnable};
        else                       hostRdata <= '0;
      end
    end
  end
endmodule

// File: rtl/chan_mailbox.sv
module chan_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PAY_W = WORD_W - CHAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata,
  output logic              irq,
  output logic              cpOutValid,
  output logic [3:0]        cpOutChan,
  output logic [27:0]       cpOutPayload,
  input  logic              cpOutPop,
  input  logic              cpInPush,
  input  logic [31:0]       cpInData,
  output logic              cpInFull
);
  mbox_strobe_t strobe;
  logic outFull, replyEmpty, ovfFlag;
  logic [CNT_W-1:0] outCount, replyCount;
  logic [WORD_W-1:0] cpOutWord;

  mbox_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .clrReq(hostWdata[BIT_OVF]),
    .outFull(outFull), .replyEmpty(replyEmpty), .strobe(strobe)
  );

  mbox_datapath #(.DEPTH(DEPTH)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .irq(irq),
    .outFull(outFull), .replyEmpty(replyEmpty), .ovfFlag(ovfFlag),
    .outCount(outCount), .replyCount(replyCount),
    .cpOutValid(cpOutValid), .cpOutWord(cpOutWord), .cpOutPop(cpOutPop),
    .cpInPush(cpInPush), .cpInData(cpInData), .cpInFull(cpInFull)
  );

  assign cpOutChan    = cpOutWord[CHAN_W-1:0];
  assign cpOutPayload = cpOutWord[WORD_W-1:CHAN_W];
endmodule

// File: rtl/chan_mailbox_checker.sv
module chan_mailbox_checker #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              hostWr,
  input logic              hostRd,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [31:0]       hostRdata,
  input logic              irq,
  input logic              cpOutPop,
  input logic              cpInPush,
  input logic              cpInFull,
  input logic              cpOutValid,
  input logic              ovfFlag,
  input logic [CNT_W-1:0]  outCount,
  input logic [CNT_W-1:0]  replyCount
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(DEPTH);

  // R3: write into a full outbound queue marks overflow and adds nothing
  a_r3_overflow_sets: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == ADDR_W'('h20) && outCount == CAP) |=> ovfFlag);
  a_r3_full_drop: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == ADDR_W'('h20) && outCount == CAP && !cpOutPop) |=> outCount == CAP);

  // R6: read of an empty reply queue returns zero
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == ADDR_W'('h00) && replyCount == '0 && !cpInPush)
      |=> (hostRdata == '0 && replyCount == '0));

  // R7: interrupt only with a pending reply
  a_r7_irq_pending: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> replyCount != '0);

  // R8: push into a full reply queue is dropped
  a_r8_reply_drop: assert property (@(posedge clk) disable iff (!rstN)
    (cpInPush && cpInFull && !hostRd) |=> replyCount == CAP);

  // R10: queues never exceed their capacity
  a_r10_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (outCount <= CAP && replyCount <= CAP));

  // R2: the co-processor view tracks the outbound fill level
  a_r2_valid_count: assert property (@(posedge clk) disable iff (!rstN)
    cpOutValid == (outCount != '0));
endmodule

bind chan_mailbox chan_mailbox_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) chk (
  .clk(clk), .rstN(rstN), .hostWr(hostWr), .hostRd(hostRd),
  .hostAddr(hostAddr), .hostRdata(hostRdata), .irq(irq),
  .cpOutPop(cpOutPop), .cpInPush(cpInPush), .cpInFull(cpInFull),
  .cpOutValid(cpOutValid), .ovfFlag(ovfFlag),
  .outCount(outCount), .replyCount(replyCount)
);

// File: tb/chan_mailbox_test.sv
`timescale 1ns/1ps
module chan_mailbox_test;
  localparam int DEPTH  = 4;
  localparam int ADDR_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [31:0] hostWdata = '0;
  logic [31:0] hostRdata;
  logic irq, cpOutValid, cpOutPop = 1'b0, cpInPush = 1'b0, cpInFull;
  logic [3:0] cpOutChan;
  logic [27:0] cpOutPayload;
  logic [31:0] cpInData = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chan_mailbox #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) uut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(int addr, logic [31:0] data);
    @(negedge clk); hostWr = 1; hostAddr = ADDR_W'(addr); hostWdata = data;
    @(negedge clk); hostWr = 0;
  endtask

  task automatic hostRead(int addr, output logic [31:0] val);
    @(negedge clk); hostRd = 1; hostAddr = ADDR_W'(addr);
    @(negedge clk); hostRd = 0; val = hostRdata;
  endtask

  task automatic cpPush(logic [31:0] data);
    @(negedge clk); cpInPush = 1; cpInData = data;
    @(negedge clk); cpInPush = 0;
  endtask

  function automatic logic [31:0] outWord(int r, int i);
    return {28'(r * 1000 + i * 37 + 5), 4'(i + r)};
  endfunction

  function automatic logic [31:0] replyWord(int r, int i);
    return {28'(r * 77 + i * 3), 4'(15 - i)};
  endfunction

  function automatic logic [31:0] stat(bit full, bit empt, bit ovf);
    return {full, empt, ovf, 29'd0};
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R9 reset state
    check("R9 irq", {31'd0, irq}, 0);
    check("R9 cpOutValid", {31'd0, cpOutValid}, 0);
    hostRead('h18, v); check("R9 status", v, stat(0, 1, 0));
    hostRead('h1C, v); check("R9 ctrl", v, 0);
    hostRead('h00, v); check("R6 empty read", v, 0);
    hostRead('h18, v); check("R6 still empty", v, stat(0, 1, 0));
    hostRead('h04, v); check("R10 unmapped", v, 0);

    for (int r = 0; r < 3; r++) begin
      // outbound fill sweep
      for (int i = 0; i < DEPTH; i++) begin
        hostWrite('h20, outWord(r, i));
        hostRead('h18, v);
        check("R10 outbound fill", v, stat(i + 1 == DEPTH, 1, 0));
      end
      hostWrite('h20, 32'hDEAD_BEEF);
      hostRead('h18, v); check("R3 overflow flag", v, stat(1, 1, 1));
      for (int i = 0; i < DEPTH; i++) begin
        check("R1 channel", {28'd0, cpOutChan}, {28'd0, outWord(r, i)[3:0]});
        check("R2 payload order", {4'd0, cpOutPayload}, {4'd0, outWord(r, i)[31:4]});
        @(negedge clk); cpOutPop = 1;
        @(negedge clk); cpOutPop = 0;
      end
      check("R3 dropped word absent", {31'd0, cpOutValid}, 0);
      hostRead('h18, v); check("R3 flag sticky", v, stat(0, 1, 1));
      hostWrite('h18, 32'h2000_0000);
      hostRead('h18, v); check("R3 flag cleared", v, stat(0, 1, 0));

      // reply fill sweep
      hostWrite('h1C, (r == 1) ? 32'h0 : 32'h1);
      hostRead('h1C, v); check("R7 ctrl readback", v, (r == 1) ? 0 : 1);
      for (int i = 0; i < DEPTH; i++) begin
        cpPush(replyWord(r, i));
        check("R8 cpInFull", {31'd0, cpInFull}, {31'd0, (i + 1 == DEPTH)});
        check("R7 irq", {31'd0, irq}, (r == 1) ? 0 : 1);
      end
      cpPush(32'h1234_5678);
      hostRead('h18, v); check("R4 status reply full", v, stat(0, 0, 0));
      for (int i = 0; i < DEPTH; i++) begin
        hostRead('h00, v); check("R5 reply order", v, replyWord(r, i));
      end
      check("R8 extra push dropped", {31'd0, irq}, 0);
      hostRead('h18, v); check("R4 reply drained", v, stat(0, 1, 0));
      hostRead('h00, v); check("R6 empty after drain", v, 0);
      hostWrite('h1C, 32'h0);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule